// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches recent page-to-frame translations for a processor's memory path. Each cycle it can accept one lookup made of a virtual address, the current address-space identifier and an access kind. Every stored entry is compared against the key at the same time, so any entry can hold any page. One cycle later the block reports whether a translation was found, the physical address formed from the cached frame and the untouched in-page offset, and whether the entry's permission bits forbid the access.

Each entry is tagged with the identifier of the address space that owns it. Two processes can therefore hold translations for the same page number side by side, and a context switch needs no flush. After a page-table walk, software or a walker installs a translation through the refill port. It can also drop every entry, or only the entries of one address space.

Top module: `tlb_asid`

## Requirements
- R1: The response is registered. `rsp_valid` is high exactly one cycle after `lk_valid` was high and low otherwise. A lookup sees the buffer contents as they were before any refill or flush that takes effect on the same clock edge.
- R2: A lookup hits only when some valid entry matches both the page number (`lk_vaddr` above the low `OFF_W` bits) and `lk_asid`. On a miss, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all zero.
- R3: On a hit, `rsp_paddr` is the entry's frame number placed above the low `OFF_W` bits of `lk_vaddr`, which pass through unchanged.
- R4: `fill_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. The `lk_acc` codes are 0 for read, 1 for write and 2 for execute; code 3 is never permitted. A hit whose access is not permitted sets `rsp_fault`. A miss never sets it.
- R5: A refill of a new translation uses the lowest-numbered invalid entry. If every entry is valid, it replaces the entry chosen by a rotating pointer. That pointer starts at entry 0 after reset and steps by one, wrapping after `ENTRIES-1`, only when it has been used.
- R6: A refill whose page number and identifier equal those of a valid entry rewrites that entry in place. No duplicate is created.
- R7: `flush_asid_valid` invalidates, in one cycle, every entry tagged with `flush_asid`. Entries of other address spaces stay usable.
- R8: `flush_all` invalidates every entry in one cycle.
- R9: A refill requested in the same cycle as either flush command is discarded.
- R10: After reset, every entry is invalid and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address space of the lookup |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none allowed |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Hit with forbidden access |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, zero on miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Owning address space |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_valid | input | 1 | Invalidate entries of one address space |
| flush_asid | input | ASID_W | Address space to invalidate |

## Verification
The assertions rely on one property of the inputs: at most one valid entry ever matches a given page and identifier. The in-place rewrite of R6 maintains this, so the single-hit property is only as strong as the refill stimulus that exercises it. The property checks also assume reset is held long enough for the first clocked edge to clear the valid bits. The stimulus therefore installs the same page under several identifiers, rewrites an existing translation, and fills the buffer past its capacity so that the rotating pointer evicts entries. Every lookup expectation is worked out from the requirements with a single owner per page and identifier in mind.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  // permission test for one access kind; code 3 is never allowed
  function automatic logic perm_allows(perm_t p, logic [1:0] acc);
    case (acc)
      ACC_READ:  perm_allows = p.r;
      ACC_WRITE: perm_allows = p.w;
      ACC_EXEC:  perm_allows = p.x;
      default:   perm_allows = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare: one match flag per entry.
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]   tag_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  tag_asid [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic [ENTRIES-1:0] match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] &&
                          (tag_vpn[g] == key_vpn) &&
                          (tag_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_readmux.sv
// AND-OR read of the matching entry (at most one match expected).
module tlb_readmux #(
  parameter int ENTRIES = 64,
  parameter int PFN_W   = 16
) (
  input  logic [ENTRIES-1:0] sel_vec,
  input  logic [PFN_W-1:0]   pfn_arr  [ENTRIES],
  input  tlb_pkg::perm_t     perm_arr [ENTRIES],
  output logic [PFN_W-1:0]   pfn_out,
  output tlb_pkg::perm_t     perm_out,
  output logic               any_out
);
  always_comb begin
    pfn_out  = '0;
    perm_out = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      pfn_out  = pfn_out  | ({PFN_W{sel_vec[i]}} & pfn_arr[i]);
      perm_out = perm_out | ({3{sel_vec[i]}} & perm_arr[i]);
    end
    any_out = |sel_vec;
  end
endmodule

// File: rtl/tlb_victim.sv
// Refill slot choice: existing match, then lowest invalid, then rotating pointer.
module tlb_victim #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               use_rr
);
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             dup_any;
  logic             free_any;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i])    dup_idx  = IDX_W'(i);
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    dup_any  = |dup_vec;
    free_any = ~&valid_vec;
    use_rr   = !dup_any && !free_any;
    if (dup_any)       victim_idx = dup_idx;
    else if (free_any) victim_idx = free_idx;
    else               victim_idx = rr_ptr;
  end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [1:0]             lk_acc,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [2:0]             fill_perm,
  input  logic                   flush_all,
  input  logic                   flush_asid_valid,
  input  logic [ASID_W-1:0]      flush_asid
);
  import tlb_pkg::*;

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // physical address: frame above the unchanged offset
  function automatic logic [PA_W-1:0] make_paddr(logic [PFN_W-1:0] pfn,
                                                 logic [VA_W-1:0]  va);
    make_paddr = {pfn, va[OFF_W-1:0]};
  endfunction

  function automatic logic [IDX_W-1:0] rr_step(logic [IDX_W-1:0] cur);
    rr_step = (cur == LAST_IDX) ? '0 : cur + 1'b1;
  endfunction

  // entry storage
  logic [ENTRIES-1:0] valid_vec;
  logic [VPN_W-1:0]   tag_vpn  [ENTRIES];
  logic [ASID_W-1:0]  tag_asid [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  perm_t              ent_perm [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  // named internal events (observed by the checker)
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic               hit_any;
  logic               fill_take;
  logic               fill_dup;
  logic               use_rr;
  logic [IDX_W-1:0]   victim_idx;
  logic [PFN_W-1:0]   hit_pfn;
  perm_t              hit_perm;
  logic               acc_ok;
  logic [VPN_W-1:0]   lk_vpn;

  assign lk_vpn    = lk_vaddr[VA_W-1:OFF_W];
  assign fill_take = fill_valid && !flush_all && !flush_asid_valid;
  assign fill_dup  = |dup_vec;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .valid_vec (valid_vec),
    .tag_vpn   (tag_vpn),
    .tag_asid  (tag_asid),
    .key_vpn   (lk_vpn),
    .key_asid  (lk_asid),
    .match_vec (hit_vec)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
    .valid_vec (valid_vec),
    .tag_vpn   (tag_vpn),
    .tag_asid  (tag_asid),
    .key_vpn   (fill_vpn),
    .key_asid  (fill_asid),
    .match_vec (dup_vec)
  );

  tlb_readmux #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_rd (
    .sel_vec  (hit_vec),
    .pfn_arr  (ent_pfn),
    .perm_arr (ent_perm),
    .pfn_out  (hit_pfn),
    .perm_out (hit_perm),
    .any_out  (hit_any)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
    .valid_vec  (valid_vec),
    .dup_vec    (dup_vec),
    .rr_ptr     (rr_ptr),
    .victim_idx (victim_idx),
    .use_rr     (use_rr)
  );

  assign acc_ok = perm_allows(hit_perm, lk_acc);

  // valid bits: flushes win over refill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (flush_all) begin
      valid_vec <= '0;
    end else if (flush_asid_valid) begin
      for (int i = 0; i < ENTRIES; i++)
        if (tag_asid[i] == flush_asid) valid_vec[i] <= 1'b0;
    end else if (fill_take) begin
      valid_vec[victim_idx] <= 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (fill_take) begin
      tag_vpn[victim_idx]  <= fill_vpn;
      tag_asid[victim_idx] <= fill_asid;
      ent_pfn[victim_idx]  <= fill_pfn;
      ent_perm[victim_idx] <= perm_t'(fill_perm);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rr_ptr <= '0;
    else if (fill_take && use_rr) rr_ptr <= rr_step(rr_ptr);
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_any;
      rsp_fault <= lk_valid && hit_any && !acc_ok;
      rsp_paddr <= (lk_valid && hit_any) ? make_paddr(hit_pfn, lk_vaddr) : '0;
    end
  end

endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               flush_all,
  input logic               fill_take,
  input logic               fill_dup,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r1_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0 && !rsp_fault));
  a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  a_r8_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
  a_r5_new_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && !fill_dup && !(&valid_vec)) |=>
      ($countones(valid_vec) == $past($countones(valid_vec)) + 1));
  a_r6_dup_fill_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && fill_dup) |=> $stable(valid_vec));
endmodule

bind tlb_asid tlb_asid_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .flush_all (flush_all),
  .fill_take (fill_take),
  .fill_dup  (fill_dup),
  .hit_vec   (hit_vec),
  .valid_vec (valid_vec)
);

// File: tb/tlb_asid_tb.sv
`timescale 1ns/1ps
module tlb_asid_tb;
  localparam int ENTRIES = 64;
  localparam int VPN_W = 20, OFF_W = 12, PFN_W = 16, ASID_W = 8;
  localparam int PA_W = PFN_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid;
  logic [VPN_W+OFF_W-1:0] lk_vaddr;
  logic [ASID_W-1:0] lk_asid;
  logic [1:0] lk_acc;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic fill_valid;
  logic [VPN_W-1:0] fill_vpn;
  logic [ASID_W-1:0] fill_asid;
  logic [PFN_W-1:0] fill_pfn;
  logic [2:0] fill_perm;
  logic flush_all, flush_asid_valid;
  logic [ASID_W-1:0] flush_asid;

  always #2.5 clk = ~clk;

  tlb_asid #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .OFF_W(OFF_W),
             .PFN_W(PFN_W), .ASID_W(ASID_W)) u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 fill, 1 lookup, 2 flush all, 3 flush one asid
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic [15:0] pfn;   // fill frame, or expected frame on lookup
    logic [2:0]  aux;   // fill perms, or access code on lookup
    logic [11:0] off;
    logic        ehit;
    logic        efault;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 20'h00010, 8'd1, 16'h0AAA, 3'b011, 12'h000, 1'b0, 1'b0},
    '{2'd0, 20'h00010, 8'd2, 16'h0BBB, 3'b101, 12'h000, 1'b0, 1'b0},
    '{2'd0, 20'h00020, 8'd1, 16'h0CCC, 3'b100, 12'h000, 1'b0, 1'b0},
    '{2'd1, 20'h00010, 8'd1, 16'h0AAA, 3'd0,   12'h123, 1'b1, 1'b0}, // R3 read ok
    '{2'd1, 20'h00010, 8'd2, 16'h0BBB, 3'd0,   12'hFFF, 1'b1, 1'b0}, // R2 same page other asid
    '{2'd1, 20'h00010, 8'd3, 16'h0000, 3'd0,   12'h001, 1'b0, 1'b0}, // R2 unknown asid misses
    '{2'd1, 20'h00010, 8'd1, 16'h0AAA, 3'd1,   12'h040, 1'b1, 1'b0}, // R4 write allowed
    '{2'd1, 20'h00010, 8'd2, 16'h0BBB, 3'd1,   12'h040, 1'b1, 1'b1}, // R4 write forbidden
    '{2'd1, 20'h00020, 8'd1, 16'h0CCC, 3'd2,   12'h008, 1'b1, 1'b0}, // R4 exec allowed
    '{2'd1, 20'h00020, 8'd1, 16'h0CCC, 3'd0,   12'h008, 1'b1, 1'b1}, // R4 read forbidden
    '{2'd1, 20'h00030, 8'd1, 16'h0000, 3'd0,   12'h008, 1'b0, 1'b0}, // R2 unknown page
    '{2'd0, 20'h00010, 8'd1, 16'h0DDD, 3'b111, 12'h000, 1'b0, 1'b0}, // R6 rewrite
    '{2'd1, 20'h00010, 8'd1, 16'h0DDD, 3'd1,   12'h555, 1'b1, 1'b0}, // R6 new frame seen
    '{2'd3, 20'h00000, 8'd1, 16'h0000, 3'd0,   12'h000, 1'b0, 1'b0},
    '{2'd1, 20'h00010, 8'd1, 16'h0000, 3'd0,   12'h000, 1'b0, 1'b0}, // R7 flushed asid misses
    '{2'd1, 20'h00010, 8'd2, 16'h0BBB, 3'd2,   12'h00C, 1'b1, 1'b0}, // R7 other asid kept
    '{2'd2, 20'h00000, 8'd0, 16'h0000, 3'd0,   12'h000, 1'b0, 1'b0},
    '{2'd1, 20'h00010, 8'd2, 16'h0000, 3'd0,   12'h000, 1'b0, 1'b0}  // R8 all gone
  };

  task automatic idle_inputs();
    lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
  endtask

  task automatic do_fill(logic [19:0] vpn, logic [7:0] asid, logic [15:0] pfn, logic [2:0] perm);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_lookup(string tag, logic [19:0] vpn, logic [7:0] asid, logic [1:0] acc,
                           logic [11:0] off, logic ehit, logic efault, logic [15:0] epfn);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_acc = acc;
    @(negedge clk);
    lk_valid = 0;
    chk({tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(rsp_hit), 64'(ehit));
    chk({tag, " fault"}, 64'(rsp_fault), 64'(efault));
    chk({tag, " paddr"}, 64'(rsp_paddr), ehit ? 64'({epfn, off}) : 64'd0);
  endtask

  task automatic do_flush(logic all, logic [7:0] asid);
    @(negedge clk);
    if (all) flush_all = 1; else begin flush_asid_valid = 1; flush_asid = asid; end
    @(negedge clk);
    flush_all = 0; flush_asid_valid = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    lk_vaddr = '0; lk_asid = '0; lk_acc = '0;
    fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0; flush_asid = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rsp_valid", 64'(rsp_valid), 0);
    chk("R10 rsp_hit", 64'(rsp_hit), 0);
    chk("R10 rsp_paddr", 64'(rsp_paddr), 0);
    rst_n = 1;
    do_lookup("R10 empty after reset", 20'h00010, 8'd1, 2'd0, 12'h0, 1'b0, 1'b0, 16'h0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        2'd0: do_fill(VEC[k].vpn, VEC[k].asid, VEC[k].pfn, VEC[k].aux);
        2'd1: do_lookup($sformatf("vec%0d", k), VEC[k].vpn, VEC[k].asid, VEC[k].aux[1:0],
                        VEC[k].off, VEC[k].ehit, VEC[k].efault, VEC[k].pfn);
        2'd2: do_flush(1'b1, 8'd0);
        default: do_flush(1'b0, VEC[k].asid);
      endcase
    end

    // R1 idle cycle: no request gives no response
    @(negedge clk);
    chk("R1 no request", 64'(rsp_valid), 0);

    // R1 lookup in the same cycle as the refill sees old contents
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00777; fill_asid = 8'd9; fill_pfn = 16'h1234; fill_perm = 3'b001;
    lk_valid = 1; lk_vaddr = {20'h00777, 12'h010}; lk_asid = 8'd9; lk_acc = 2'd0;
    @(negedge clk);
    idle_inputs();
    chk("R1 same-edge refill not yet visible", 64'(rsp_hit), 0);
    do_lookup("R1 refill visible next", 20'h00777, 8'd9, 2'd0, 12'h010, 1'b1, 1'b0, 16'h1234);

    // R9 refill discarded when a flush coincides
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00055; fill_asid = 8'd6; fill_pfn = 16'h0055; fill_perm = 3'b111;
    flush_asid_valid = 1; flush_asid = 8'd4;
    @(negedge clk);
    idle_inputs();
    do_lookup("R9 fill with flush_asid", 20'h00055, 8'd6, 2'd0, 12'h0, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00056; fill_asid = 8'd6; fill_pfn = 16'h0056; fill_perm = 3'b111;
    flush_all = 1;
    @(negedge clk);
    idle_inputs();
    do_lookup("R9 fill with flush_all", 20'h00056, 8'd6, 2'd0, 12'h0, 1'b0, 1'b0, 16'h0);
    do_lookup("R8 earlier entry gone", 20'h00777, 8'd9, 2'd0, 12'h0, 1'b0, 1'b0, 16'h0);

    // R5 fill to capacity, then rotating eviction from entry 0
    for (int i = 0; i < ENTRIES; i++)
      do_fill(20'h00100 + 20'(i), 8'd5, 16'(i), 3'b111);
    do_lookup("R5 all stored first", 20'h00100, 8'd5, 2'd0, 12'h0, 1'b1, 1'b0, 16'd0);
    do_lookup("R5 all stored last", 20'h00100 + 20'(ENTRIES - 1), 8'd5, 2'd0, 12'h0, 1'b1, 1'b0,
              16'(ENTRIES - 1));
    do_fill(20'h00200, 8'd5, 16'h0200, 3'b111);
    do_lookup("R5 entry0 evicted", 20'h00100, 8'd5, 2'd0, 12'h0, 1'b0, 1'b0, 16'd0);
    do_lookup("R5 entry1 kept", 20'h00101, 8'd5, 2'd0, 12'h0, 1'b1, 1'b0, 16'd1);
    do_lookup("R5 new entry", 20'h00200, 8'd5, 2'd0, 12'h0, 1'b1, 1'b0, 16'h0200);
    do_fill(20'h00201, 8'd5, 16'h0201, 3'b111);
    do_lookup("R5 pointer stepped", 20'h00101, 8'd5, 2'd0, 12'h0, 1'b0, 1'b0, 16'd0);
    do_lookup("R5 entry2 kept", 20'h00102, 8'd5, 2'd1, 12'h0, 1'b1, 1'b0, 16'd2);
    // R4 access code 3 always faults even with full permissions
    do_lookup("R4 code3 faults", 20'h00102, 8'd5, 2'd3, 12'h0AB, 1'b1, 1'b1, 16'd2);

    // R5 invalid entry preferred over the pointer: free one slot, refill it
    do_fill(20'h00300, 8'd7, 16'h0300, 3'b001);
    do_flush(1'b0, 8'd7);
    do_fill(20'h00301, 8'd8, 16'h0301, 3'b001);
    do_lookup("R5 free slot reused", 20'h00103, 8'd5, 2'd0, 12'h0, 1'b1, 1'b0, 16'd3);
    do_lookup("R5 refill present", 20'h00301, 8'd8, 2'd0, 12'h0, 1'b1, 1'b0, 16'h0301);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule